// File: doc/BRIEF.md
# Keyboard Port Wiring Mode Detector

After reset, this block works out whether the keyboard controller sits in a board wired for the legacy AT arrangement or for the two-device PS/2 arrangement. It does this by driving a slow square wave on the keyboard-data output pin and watching the keyboard-data input pin. A PS/2 board loops the output back to the input. An AT board leaves the input on its pull-up, so the input stays high while the output toggles.

Two results come out: a latched mode flag and a completion flag. The rest of the controller stays idle until the completion flag is set. It then uses the mode flag to choose how its shared pins and status bits behave. Once the decision is made, the data output pin carries the serial channel's own data bit.

Detection has three stages:
- **Wait:** the block waits until the data input has been high for `START_CYC` cycles.
- **Probe:** it drives `HALF_CYC` cycles high, then `HALF_CYC` cycles low, and repeats.
- **Decide:** it reads the input on the last cycle of each low phase. Two low readings in a row select PS/2. With no such pair, AT is selected `TIMEOUT_CYC` cycles after probing began.

Top module: `kbmd_detect`

## Requirements
- R1: While reset is asserted, and immediately after it, `detect_done` is 0, `mode_ps2` is 0 and `kbd_dout` is 1.
- R2: Before probing starts, `kbd_dout` is held at 1. Probing starts on the clock edge at which `kbd_din` has been 1 for `START_CYC` consecutive edges after reset.
- R3: Let edge E be the edge on which probing starts.
  - `kbd_dout` is 1 for `HALF_CYC` cycles, then 0 for `HALF_CYC` cycles, and the pattern repeats.
  - The value of `kbd_dout_sys` has no effect on `kbd_dout` during probing.
- R4: `kbd_din` is sampled on the last clock edge of each low phase, which is edge E+2k·`HALF_CYC` for k ≥ 1.
- R5: Two consecutive low samples of `kbd_din` set `mode_ps2`=1 and `detect_done`=1 at that second sample edge. With a full loopback this is edge E+4·`HALF_CYC`.
- R6: If no PS/2 decision has been made, edge E+`TIMEOUT_CYC` sets `detect_done`=1 with `mode_ps2`=0 (AT).
- R7: A single low sample followed by a high sample does not select PS/2. The count of consecutive low samples starts again from zero.
- R8: Once `detect_done` is 1, it and `mode_ps2` stay unchanged until the next reset, whatever `kbd_din` does.
- R9: Once `detect_done` is 1, `kbd_dout` equals `kbd_dout_sys` in the same cycle.
- R10: If `kbd_din` is still low when reset is released, the start delay of `START_CYC` edges is counted only from when `kbd_din` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_din | input | 1 | Keyboard-data input pin (pulled up; looped back on PS/2 boards) |
| kbd_dout_sys | input | 1 | Data bit from the serial channel, passed to the pin after detection |
| kbd_dout | output | 1 | Keyboard-data output pin |
| mode_ps2 | output | 1 | Latched wiring mode: 1 PS/2, 0 AT |
| detect_done | output | 1 | Detection finished; the controller may start |

## Verification
All timing is counted in edges from reset release, and each check is placed on a specific edge:
- The start edge is `START_CYC`, or the time `kbd_din` was held low plus `START_CYC` when it is held low.
- A loopback decision is due 4·`HALF_CYC` edges after the start edge.
- A timeout decision is due `TIMEOUT_CYC` edges after the start edge.

The bench advances one falling edge per rising edge and samples outputs there. It checks each result one edge before it is due (still absent) and on the due edge (present), so an off-by-one in any counter is caught. The pin pattern is checked one edge into each phase, and again with `kbd_dout_sys` held opposite to the expected level.

// File: rtl/kbmd_pkg.sv
package kbmd_pkg;

  typedef enum logic [1:0] {
    MD_WAIT  = 2'd0,
    MD_PROBE = 2'd1,
    MD_FINAL = 2'd2
  } md_state_t;

  // width of a counter that must hold values 0..lim
  function automatic int cnt_width(input int lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // edge index, relative to probe start, of the k-th low-phase sample (k >= 1)
  function automatic int sample_edge(input int half, input int k);
    return 2 * half * k;
  endfunction

endpackage

// File: rtl/kbmd_arm.sv
// Counts consecutive high cycles of the data input while waiting; fires once.
module kbmd_arm #(
  parameter int START_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  input  logic din,
  output logic arm
);
  import kbmd_pkg::*;
  localparam int AW = cnt_width(START_CYC);

  logic [AW-1:0] hi_cnt;
  logic          at_lim;

  assign at_lim = (hi_cnt == AW'(START_CYC - 1));
  assign arm    = waiting && din && at_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (!waiting || !din) begin
      hi_cnt <= '0;
    end else if (!at_lim) begin
      hi_cnt <= hi_cnt + AW'(1);
    end
  end
endmodule

// File: rtl/kbmd_probe.sv
// Generates the probe square wave, the sample strobe and the timeout strobe.
module kbmd_probe #(
  parameter int HALF_CYC    = 11000,
  parameter int TIMEOUT_CYC = 3200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic probe_level,
  output logic sample_evt,
  output logic timeout_evt
);
  import kbmd_pkg::*;
  localparam int PW = cnt_width(HALF_CYC);
  localparam int TW = cnt_width(TIMEOUT_CYC);

  logic [PW-1:0] ph_cnt;
  logic          low_phase;
  logic [TW-1:0] to_cnt;
  logic          ph_end;

  assign ph_end      = (ph_cnt == PW'(HALF_CYC - 1));
  assign probe_level = ~low_phase;
  assign sample_evt  = run && low_phase && ph_end;
  assign timeout_evt = run && (to_cnt == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      ph_cnt    <= '0;
      low_phase <= 1'b0;
      to_cnt    <= '0;
    end else begin
      if (ph_end) begin
        ph_cnt    <= '0;
        low_phase <= ~low_phase;
      end else begin
        ph_cnt <= ph_cnt + PW'(1);
      end
      if (!timeout_evt) to_cnt <= to_cnt + TW'(1);
    end
  end
endmodule

// File: rtl/kbmd_judge.sv
// Counts consecutive low-phase samples in which the input echoed low.
module kbmd_judge #(
  parameter int ECHO_NEED = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sample_evt,
  input  logic din,
  output logic pick_ps2
);
  import kbmd_pkg::*;
  localparam int HW = cnt_width(ECHO_NEED);

  logic [HW-1:0] hits;

  assign pick_ps2 = sample_evt && !din && (hits == HW'(ECHO_NEED - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      hits <= '0;
    end else if (sample_evt) begin
      hits <= din ? '0 : (hits + HW'(1));
    end
  end
endmodule

// File: rtl/kbmd_detect.sv
module kbmd_detect #(
  parameter int START_CYC   = 50000,
  parameter int HALF_CYC    = 11000,
  parameter int TIMEOUT_CYC = 3200000,
  parameter int ECHO_NEED   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kbd_din,
  input  logic kbd_dout_sys,
  output logic kbd_dout,
  output logic mode_ps2,
  output logic detect_done
);
  import kbmd_pkg::*;

  md_state_t state;
  logic      waiting;
  logic      probe_on;
  logic      arm;
  logic      probe_level;
  logic      sample_evt;
  logic      timeout_evt;
  logic      pick_ps2;

  assign waiting  = (state == MD_WAIT);
  assign probe_on = (state == MD_PROBE);

  kbmd_arm #(.START_CYC(START_CYC)) u_arm (
    .clk(clk), .rst_n(rst_n), .waiting(waiting), .din(kbd_din), .arm(arm)
  );

  kbmd_probe #(.HALF_CYC(HALF_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_probe (
    .clk(clk), .rst_n(rst_n), .run(probe_on), .probe_level(probe_level),
    .sample_evt(sample_evt), .timeout_evt(timeout_evt)
  );

  kbmd_judge #(.ECHO_NEED(ECHO_NEED)) u_judge (
    .clk(clk), .rst_n(rst_n), .run(probe_on), .sample_evt(sample_evt),
    .din(kbd_din), .pick_ps2(pick_ps2)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= MD_WAIT;
      mode_ps2    <= 1'b0;
      detect_done <= 1'b0;
    end else begin
      unique case (state)
        MD_WAIT:  if (arm) state <= MD_PROBE;
        MD_PROBE: begin
          if (pick_ps2) begin
            state       <= MD_FINAL;
            mode_ps2    <= 1'b1;
            detect_done <= 1'b1;
          end else if (timeout_evt) begin
            state       <= MD_FINAL;
            mode_ps2    <= 1'b0;
            detect_done <= 1'b1;
          end
        end
        default:  state <= MD_FINAL;
      endcase
    end
  end

  always_comb begin
    if (detect_done)   kbd_dout = kbd_dout_sys;
    else if (probe_on) kbd_dout = probe_level;
    else               kbd_dout = 1'b1;
  end
endmodule

// File: rtl/kbmd_detect_chk.sv
module kbmd_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic kbd_din,
  input logic kbd_dout_sys,
  input logic kbd_dout,
  input logic mode_ps2,
  input logic detect_done,
  input logic probe_on,
  input logic sample_evt
);
  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    detect_done |=> detect_done);
  // R8
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    detect_done |=> $stable(mode_ps2));
  // R1
  mode_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ps2 |-> detect_done);
  // R5
  ps2_from_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_ps2) |-> ($past(sample_evt) && !$past(kbd_din)));
  // R9
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    detect_done |-> (kbd_dout == kbd_dout_sys));
  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!detect_done && !probe_on) |-> kbd_dout);
  // R4
  sample_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> (probe_on && !kbd_dout));
endmodule

bind kbmd_detect kbmd_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .kbd_din(kbd_din), .kbd_dout_sys(kbd_dout_sys),
  .kbd_dout(kbd_dout), .mode_ps2(mode_ps2), .detect_done(detect_done),
  .probe_on(probe_on), .sample_evt(sample_evt)
);

// File: tb/tb_kbmd_detect.sv
module tb_kbmd_detect;
  localparam int ST = 40;
  localparam int H  = 10;
  localparam int TO = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kbd_dout_sys = 1'b1;
  logic kbd_dout, mode_ps2, detect_done;
  logic kbd_din;
  logic loop_en = 1'b0;
  logic force_en = 1'b0;
  logic force_val = 1'b1;
  int   n_chk = 0;
  int   n_fail = 0;

  assign kbd_din = force_en ? force_val : (loop_en ? kbd_dout : 1'b1);

  always #10 clk = ~clk;

  kbmd_detect #(.START_CYC(ST), .HALF_CYC(H), .TIMEOUT_CYC(TO), .ECHO_NEED(2)) dut (
    .clk(clk), .rst_n(rst_n), .kbd_din(kbd_din), .kbd_dout_sys(kbd_dout_sys),
    .kbd_dout(kbd_dout), .mode_ps2(mode_ps2), .detect_done(detect_done)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // reset, then release at a negedge; edge count from release is then 0
  task automatic start_run(input logic loop, input logic hold_low);
    rst_n = 1'b0; loop_en = loop; force_en = hold_low; force_val = 1'b0;
    kbd_dout_sys = 1'b0;
    edges(3);
    check("R1 done in reset", detect_done, 1'b0);
    check("R1 mode in reset", mode_ps2, 1'b0);
    check("R1 dout in reset", kbd_dout, 1'b1);
    rst_n = 1'b1;
  endtask

  task automatic t_ps2_loop();
    start_run(1'b1, 1'b0);
    edges(1);
    check("R1 done after release", detect_done, 1'b0);
    edges(ST - 2);
    check("R2 dout high before start", kbd_dout, 1'b1);
    edges(2);              // edge ST+1: high phase
    check("R3 high phase", kbd_dout, 1'b1);
    edges(H);              // edge ST+H+1: low phase, sys=0 not visible anyway
    check("R3 low phase", kbd_dout, 1'b0);
    edges(4 * H - H - 2);  // edge ST+4H-1
    check("R5 not yet done", detect_done, 1'b0);
    edges(1);              // edge ST+4H
    check("R5 done at second echo", detect_done, 1'b1);
    check("R5 mode ps2", mode_ps2, 1'b1);
    kbd_dout_sys = 1'b1;
    #1 check("R9 dout follows sys 1", kbd_dout, 1'b1);
    kbd_dout_sys = 1'b0;
    #1 check("R9 dout follows sys 0", kbd_dout, 1'b0);
    loop_en = 1'b0; force_en = 1'b1; force_val = 1'b1;
    edges(30);
    force_val = 1'b0;
    edges(30);
    check("R8 mode held", mode_ps2, 1'b1);
    check("R8 done held", detect_done, 1'b1);
  endtask

  task automatic t_at_timeout();
    start_run(1'b0, 1'b0);
    kbd_dout_sys = 1'b0;
    edges(ST + 1);
    check("R3 high phase ignores sys", kbd_dout, 1'b1);
    kbd_dout_sys = 1'b1;
    edges(H);
    check("R3 low phase ignores sys", kbd_dout, 1'b0);
    edges(H);
    check("R3 second high phase", kbd_dout, 1'b1);
    edges(TO - 2 * H - 2); // edge ST+TO-1
    check("R6 not yet timed out", detect_done, 1'b0);
    edges(1);
    check("R6 done at timeout", detect_done, 1'b1);
    check("R6 mode AT", mode_ps2, 1'b0);
    edges(20);
    check("R8 AT mode held", mode_ps2, 1'b0);
  endtask

  task automatic t_single_echo();
    start_run(1'b1, 1'b0);
    edges(ST + 2 * H);     // first sample taken low
    check("R7 no decision after one echo", detect_done, 1'b0);
    force_en = 1'b1; force_val = 1'b1;
    edges(TO - 2 * H - 1); // edge ST+TO-1
    check("R7 still undecided", detect_done, 1'b0);
    edges(1);
    check("R7 done via timeout", detect_done, 1'b1);
    check("R7 mode AT", mode_ps2, 1'b0);
  endtask

  task automatic t_held_low();
    start_run(1'b1, 1'b1);
    edges(25 + ST);
    check("R10 dout high while input held low", kbd_dout, 1'b1);
    check("R10 no start while input low", detect_done, 1'b0);
    force_en = 1'b0;       // input released after 25+ST edges
    edges(ST + 4 * H - 1);
    check("R10 not yet done", detect_done, 1'b0);
    edges(1);
    check("R10 ps2 after delayed start", detect_done, 1'b1);
    check("R10 mode ps2", mode_ps2, 1'b1);
  endtask

  initial begin
    t_ps2_loop();
    t_at_timeout();
    t_single_echo();
    t_held_low();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule